// File: doc/BRIEF.md
# Multiplexed Servo Pulse Sequencer

This block drives a bank of hobby-servo outputs from a single up-counter and a single compare value. The channels are served strictly one after another, so no more than one output is ever high. Each channel holds a pulse width in counter ticks and an active flag, both written through a simple write port. A compare match closes the current slot, opens the next one and reloads the compare value. After the last configured channel, the block waits out a refresh gap, restarts the counter from zero and begins again with channel 0.

The counter advances once per prescaled tick, and the divide ratio (2, 8, 32 or 128) is captured when the block starts. Starting the block schedules the first match one millisecond later. A stop request is only recorded as pending. It takes effect at the close of the refresh gap, so the last pulse always runs to full length. An enable request that arrives while a stop is pending withdraws the stop and leaves the running sequence untouched.

Top module: `servo_seq`

## Requirements
- R1: After reset every servo output is low and `running` is low.
- R2: At most one servo output is high in any cycle. Slots run in ascending channel order, and each slot opens in the same cycle that the previous slot closes.
- R3: The output of an active channel stays high for exactly width × P clock cycles, where P is the divide ratio in use.
- R4: An inactive channel (active flag 0) keeps its output low but still takes its full slot of width × P cycles before the next channel opens.
- R5: One frame serves channels 0 to L-1, where L = min(NUM_CH, servo_count). With servo_count = 0, every output stays low.
- R6: Channel 0 opens at counter value 0. The frame length in ticks is the larger of two values: the refresh period (REFRESH_MS × CLK_KHZ / P) and the count at which the last slot closes plus a guard of max(1, GUARD_CYC / P).
- R7: When an enable request starts an idle block, channel 0 opens CLK_KHZ / P ticks later, which is one millisecond. The request is sampled at clock edge E, and the opening comes at edge E + (CLK_KHZ / P) × P.
- R8: `presc_sel` selects the divide ratio P, with codes 0, 1, 2 and 3 giving 2, 8, 32 and 128. The value is sampled at start and held until the block stops.
- R9: A disable request while running does not shorten the current pulse. `running` falls, and all outputs are low, at the close of the refresh gap that follows, and no new frame begins.
- R10: An enable request while a stop is pending cancels the stop and does not restart or shift the sequence.
- R11: An enable request while running with no stop pending has no effect. A disable request while idle has no effect.
- R12: A write to a channel during that channel's pulse does not change the pulse in progress. The new value applies from the channel's next slot.
- R13: A programmed width of 0 is served as a width of 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Enable request pulse |
| dis_req | input | 1 | Disable request pulse |
| presc_sel | input | 2 | Divide-ratio code, sampled at start |
| servo_count | input | $clog2(NUM_CH+1) | Number of configured servos |
| wr_en | input | 1 | Channel write strobe |
| wr_ch | input | $clog2(NUM_CH) | Channel written |
| wr_ticks | input | CNT_W | Pulse width in ticks |
| wr_active | input | 1 | Active flag written |
| servo_out | output | NUM_CH | Servo pulse outputs |
| running | output | 1 | Counter is running |

## Verification
A wrong slot index or gap flag appears at once on the outputs as a pulse on the wrong pin, a skipped slot or a second output high. Because the behavioural model is compared on every clock, it shows up within the cycle of the faulty match. A wrong compare value or tick count does not show until the next match, when an edge arrives early or late. A mishandled pending stop shows as a lost final pulse or as `running` falling at the wrong edge, so each frame boundary is a place where such an error becomes visible.

// File: rtl/servo_seq_pkg.sv
package servo_seq_pkg;

    localparam int MAX_DIV = 128;
    localparam int DIV_W   = $clog2(MAX_DIV);

    typedef enum logic [1:0] {
        PSC_DIV2   = 2'd0,
        PSC_DIV8   = 2'd1,
        PSC_DIV32  = 2'd2,
        PSC_DIV128 = 2'd3
    } psc_code_t;

    // log2 of the divide ratio for a code
    function automatic int psc_shift(input psc_code_t code);
        return 1 + 2 * int'(code);
    endfunction

    // last value of the divider before it wraps
    function automatic logic [DIV_W-1:0] psc_last(input psc_code_t code);
        return DIV_W'((2 << (2 * int'(code))) - 1);
    endfunction

    // convert a count of input clock cycles into ticks, never below one
    function automatic int cyc_to_ticks(input int cyc, input psc_code_t code);
        int t;
        t = cyc >> psc_shift(code);
        return (t < 1) ? 1 : t;
    endfunction

endpackage

// File: rtl/servo_prescale.sv
module servo_prescale
    import servo_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      running,
    input  psc_code_t sel_in,
    output psc_code_t sel_q,
    output logic      tick
);

    logic [DIV_W-1:0] pdiv;
    logic             at_last;

    assign at_last = (pdiv == psc_last(sel_q));
    assign tick    = running && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pdiv  <= '0;
            sel_q <= PSC_DIV2;
        end else if (start) begin
            pdiv  <= '0;
            sel_q <= sel_in;
        end else if (running) begin
            pdiv <= at_last ? '0 : pdiv + 1'b1;
        end
    end

endmodule

// File: rtl/servo_chan_bank.sv
module servo_chan_bank #(
    parameter int NUM_CH = 12,
    parameter int CNT_W  = 16,
    localparam int IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_ch,
    input  logic [CNT_W-1:0] wr_ticks,
    input  logic             wr_active,
    input  logic [IW-1:0]    rd_ch,
    output logic [CNT_W-1:0] rd_width,
    output logic             rd_active
);

    logic [CNT_W-1:0] width_q  [NUM_CH];
    logic             active_q [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                width_q[i]  <= '0;
                active_q[i] <= 1'b0;
            end else if (wr_en && (wr_ch == IW'(i))) begin
                width_q[i]  <= wr_ticks;
                active_q[i] <= wr_active;
            end
        end
    end

    // read port; a zero width is served as one tick (R13)
    always_comb begin
        rd_width  = CNT_W'(1);
        rd_active = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_ch == IW'(i)) begin
                rd_width  = (width_q[i] == '0) ? CNT_W'(1) : width_q[i];
                rd_active = active_q[i];
            end
        end
    end

    p_width_nonzero_r13: assert property (@(posedge clk) disable iff (rst)
        rd_width != '0);

endmodule

// File: rtl/servo_sequencer.sv
module servo_sequencer
    import servo_seq_pkg::*;
#(
    parameter int NUM_CH     = 12,
    parameter int CNT_W      = 16,
    parameter int CLK_KHZ    = 1000,
    parameter int REFRESH_MS = 20,
    parameter int GUARD_CYC  = 32,
    localparam int IW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SCW       = $clog2(NUM_CH + 1),
    localparam int START_CYC = CLK_KHZ,
    localparam int REFR_CYC  = CLK_KHZ * REFRESH_MS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_req,
    input  logic             dis_req,
    input  psc_code_t        sel_in,
    input  psc_code_t        sel_q,
    input  logic [SCW-1:0]   servo_count,
    input  logic             tick,
    input  logic [CNT_W-1:0] rd_width,
    input  logic             rd_active,
    output logic [IW-1:0]    rd_ch,
    output logic             start,
    output logic             running,
    output logic [NUM_CH-1:0] servo_out
);

    logic [CNT_W-1:0] cnt, cmp;
    logic [IW-1:0]    cur_ch;
    logic             in_gap;
    logic             pend;

    logic [CNT_W-1:0] cnt_inc, base, gap_cnt, refr_t, guard_t, end_cmp;
    logic [SCW-1:0]   nxt, limit;
    logic             match, has_next, stop_evt;

    assign start    = !running && en_req;
    assign cnt_inc  = cnt + 1'b1;
    assign match    = tick && (cnt_inc == cmp);
    assign base     = in_gap ? '0 : cnt_inc;
    assign nxt      = in_gap ? '0 : SCW'(cur_ch) + SCW'(1);
    assign limit    = (servo_count < SCW'(NUM_CH)) ? servo_count : SCW'(NUM_CH);
    assign has_next = nxt < limit;
    assign rd_ch    = nxt[IW-1:0];
    assign stop_evt = match && in_gap && pend;

    assign refr_t   = CNT_W'(cyc_to_ticks(REFR_CYC, sel_q));
    assign guard_t  = CNT_W'(cyc_to_ticks(GUARD_CYC, sel_q));
    assign gap_cnt  = base + guard_t;
    assign end_cmp  = (gap_cnt > refr_t) ? gap_cnt : refr_t;

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            pend      <= 1'b0;
            cnt       <= '0;
            cmp       <= '0;
            cur_ch    <= '0;
            in_gap    <= 1'b1;
            servo_out <= '0;
        end else if (!running) begin
            if (en_req) begin
                running <= 1'b1;
                pend    <= 1'b0;
                cnt     <= '0;
                cmp     <= CNT_W'(cyc_to_ticks(START_CYC, sel_in));
                in_gap  <= 1'b1;
            end
        end else if (stop_evt) begin
            running   <= 1'b0;
            pend      <= 1'b0;
            cnt       <= '0;
            servo_out <= '0;
        end else begin
            if (dis_req)     pend <= 1'b1;
            else if (en_req) pend <= 1'b0;
            if (match) begin
                cnt       <= base;
                servo_out <= '0;
                if (has_next) begin
                    servo_out[rd_ch] <= rd_active;
                    cmp              <= base + rd_width;
                    cur_ch           <= rd_ch;
                    in_gap           <= 1'b0;
                end else begin
                    cmp    <= end_cmp;
                    in_gap <= 1'b1;
                end
            end else if (tick) begin
                cnt <= cnt_inc;
            end
        end
    end

    p_one_high_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(servo_out));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !running |-> (servo_out == '0));

    p_stop_at_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> $past(in_gap && pend));

    p_pend_needs_run_r10: assert property (@(posedge clk) disable iff (rst)
        pend |-> running);

    p_cnt_below_cmp_r6: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt < cmp));

endmodule

// File: rtl/servo_seq.sv
module servo_seq
    import servo_seq_pkg::*;
#(
    parameter int NUM_CH     = 12,
    parameter int CNT_W      = 16,
    parameter int CLK_KHZ    = 1000,
    parameter int REFRESH_MS = 20,
    parameter int GUARD_CYC  = 32,
    localparam int IW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SCW       = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_req,
    input  logic              dis_req,
    input  logic [1:0]        presc_sel,
    input  logic [SCW-1:0]    servo_count,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_ch,
    input  logic [CNT_W-1:0]  wr_ticks,
    input  logic              wr_active,
    output logic [NUM_CH-1:0] servo_out,
    output logic              running
);

    psc_code_t        sel_q;
    logic             tick, start, rd_active;
    logic [IW-1:0]    rd_ch;
    logic [CNT_W-1:0] rd_width;

    servo_prescale u_psc (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .running (running),
        .sel_in  (psc_code_t'(presc_sel)),
        .sel_q   (sel_q),
        .tick    (tick)
    );

    servo_chan_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_ticks  (wr_ticks),
        .wr_active (wr_active),
        .rd_ch     (rd_ch),
        .rd_width  (rd_width),
        .rd_active (rd_active)
    );

    servo_sequencer #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .CLK_KHZ(CLK_KHZ),
        .REFRESH_MS(REFRESH_MS), .GUARD_CYC(GUARD_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .en_req      (en_req),
        .dis_req     (dis_req),
        .sel_in      (psc_code_t'(presc_sel)),
        .sel_q       (sel_q),
        .servo_count (servo_count),
        .tick        (tick),
        .rd_width    (rd_width),
        .rd_active   (rd_active),
        .rd_ch       (rd_ch),
        .start       (start),
        .running     (running),
        .servo_out   (servo_out)
    );

    p_tick_only_running_r8: assert property (@(posedge clk) disable iff (rst)
        tick |-> running);

endmodule

// File: tb/servo_seq_test.sv
module servo_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int CW         = 16;
    localparam int KHZ        = 256;
    localparam int RMS        = 20;
    localparam int GCYC       = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_req = 1'b0, dis_req = 1'b0, wr_en = 1'b0, wr_active = 1'b0;
    logic [1:0]    presc_sel = 2'd0;
    logic [2:0]    servo_count = 3'd0;
    logic [1:0]    wr_ch = 2'd0;
    logic [CW-1:0] wr_ticks = '0;
    logic [NCH-1:0] servo_out;
    logic running;

    int checks = 0, failures = 0, cyc = 0;
    string cur_req = "R1";
    logic [NCH-1:0] seen = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    servo_seq #(.NUM_CH(NCH), .CNT_W(CW), .CLK_KHZ(KHZ), .REFRESH_MS(RMS),
                .GUARD_CYC(GCYC)) uut (
        .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
        .presc_sel(presc_sel), .servo_count(servo_count), .wr_en(wr_en),
        .wr_ch(wr_ch), .wr_ticks(wr_ticks), .wr_active(wr_active),
        .servo_out(servo_out), .running(running));

    // ---------------- behavioural reference ----------------
    int m_w [NCH];
    int m_a [NCH];
    int m_run, m_pend, m_idx, m_cnt, m_cmp, m_pdiv, m_sel, m_out;
    int p, lim, nx, base, w, g, r;
    bit tk, mt;

    function automatic int ticks_of(input int c, input int s);
        int t;
        t = c / (2 << (2 * s));
        return (t < 1) ? 1 : t;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_pend = 0; m_idx = -1; m_cnt = 0; m_cmp = 0;
            m_pdiv = 0; m_sel = 0; m_out = 0;
            for (int i = 0; i < NCH; i++) begin m_w[i] = 0; m_a[i] = 0; end
        end else begin
            p  = 2 << (2 * m_sel);
            tk = (m_run != 0) && (m_pdiv == p - 1);
            if (m_run != 0) m_pdiv = (m_pdiv == p - 1) ? 0 : m_pdiv + 1;
            mt = tk && (m_cnt + 1 == m_cmp);
            if (m_run == 0) begin
                if (en_req) begin
                    m_run = 1; m_pend = 0; m_cnt = 0; m_sel = presc_sel;
                    m_pdiv = 0; m_idx = -1; m_cmp = ticks_of(KHZ, presc_sel);
                end
            end else if (mt && m_idx < 0 && m_pend != 0) begin
                m_run = 0; m_pend = 0; m_out = 0; m_cnt = 0;
            end else begin
                if (dis_req) m_pend = 1;
                else if (en_req) m_pend = 0;
                if (mt) begin
                    base  = (m_idx < 0) ? 0 : m_cnt + 1;
                    m_cnt = base;
                    m_out = 0;
                    nx    = m_idx + 1;
                    lim   = (servo_count < NCH) ? servo_count : NCH;
                    if (nx < lim) begin
                        w     = (m_w[nx] == 0) ? 1 : m_w[nx];
                        m_cmp = base + w;
                        m_out = m_a[nx] << nx;
                        m_idx = nx;
                    end else begin
                        g     = base + ticks_of(GCYC, m_sel);
                        r     = ticks_of(KHZ * RMS, m_sel);
                        m_cmp = (g > r) ? g : r;
                        m_idx = -1;
                    end
                end else if (tk) begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (wr_en) begin m_w[wr_ch] = wr_ticks; m_a[wr_ch] = wr_active; end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model, plus one-hot rule (R2)
    always @(negedge clk) begin
        cyc++;
        seen = seen | servo_out;
        if (!rst) begin
            chk(int'(servo_out) == m_out && int'(running) == m_run, cur_req,
                int'({running, servo_out}), (m_run << NCH) | m_out);
            chk($countones(servo_out) <= 1, "R2", int'(servo_out), 0);
        end
        if (cyc > 190000) begin
            chk(0, "watchdog", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic write_ch(input int ch, input int t, input bit a);
        wr_en = 1; wr_ch = 2'(ch); wr_ticks = CW'(t); wr_active = a;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse_en();
        en_req = 1; @(negedge clk); en_req = 0;
    endtask

    task automatic pulse_dis();
        dis_req = 1; @(negedge clk); dis_req = 0;
    endtask

    task automatic wait_rise(input int ch, output int n);
        n = 0;
        while (!servo_out[ch]) begin @(negedge clk); n++; end
    endtask

    task automatic high_len(input int ch, output int n);
        n = 0;
        while (servo_out[ch]) begin @(negedge clk); n++; end
    endtask

    task automatic next_rise(input int ch, output int n);
        int a, b;
        high_len(ch, a);
        wait_rise(ch, b);
        n = a + b;
    endtask

    int n;

    initial begin
        repeat (3) @(negedge clk);
        chk(servo_out == '0 && running == 1'b0, "R1", int'({running, servo_out}), 0);
        rst = 0;

        // frame with P = 8 (R8 code 1): start 32 ticks, refresh 640 ticks
        cur_req = "R3";
        write_ch(0, 5, 1); write_ch(1, 3, 0); write_ch(2, 7, 1); write_ch(3, 2, 1);
        servo_count = 3'd3; presc_sel = 2'd1;
        seen = '0;
        en_req = 1; @(negedge clk); en_req = 0;
        wait_rise(0, n);  chk(n == 256, "R7", n, 256);
        high_len(0, n);   chk(n == 40, "R3", n, 40);
        cur_req = "R4";
        wait_rise(2, n);  chk(n == 24, "R4", n, 24);
        high_len(2, n);   chk(n == 56, "R3", n, 56);
        cur_req = "R6";
        wait_rise(0, n);  chk(n == 5000, "R6", n, 5000);
        chk(seen[3] == 1'b0 && seen[1] == 1'b0, "R5", int'(seen), 5);

        // enable while running, nothing pending: ignored
        cur_req = "R11";
        pulse_en();
        next_rise(0, n);  chk(n == 5119, "R11", n, 5119);

        // write during the pulse in progress
        cur_req = "R12";
        write_ch(0, 9, 1);
        high_len(0, n);   chk(n == 39, "R12", n, 39);
        wait_rise(0, n);  chk(n == 5080, "R12", n, 5080);
        high_len(0, n);   chk(n == 72, "R12", n, 72);

        // deferred disable
        cur_req = "R9";
        wait_rise(0, n);
        pulse_dis();
        high_len(0, n);   chk(n == 71, "R9", n, 71);
        n = 0;
        while (running) begin @(negedge clk); n++; end
        chk(n == 5048, "R9", n, 5048);
        seen = '0;
        repeat (300) @(negedge clk);
        chk(seen == '0 && !running, "R9", int'({running, seen}), 0);
        cur_req = "R11";
        pulse_dis();
        repeat (20) @(negedge clk);
        chk(running == 1'b0, "R11", int'(running), 0);

        // P = 32 (code 2): guard-limited frame of 171 ticks
        cur_req = "R8";
        write_ch(0, 70, 1); write_ch(1, 60, 0); write_ch(2, 40, 1);
        presc_sel = 2'd2;
        en_req = 1; @(negedge clk); en_req = 0;
        presc_sel = 2'd0;
        wait_rise(0, n);  chk(n == 256, "R8", n, 256);
        cur_req = "R10";
        dis_req = 1; @(negedge clk); dis_req = 0; en_req = 1;
        @(negedge clk); en_req = 0;
        next_rise(0, n);  chk(n == 5470, "R10", n, 5470);
        chk(running == 1'b1, "R10", int'(running), 1);

        // zero width, then single-channel sequence
        cur_req = "R13";
        servo_count = 3'd1;
        write_ch(0, 0, 1);
        next_rise(0, n);  chk(n == 5119, "R5", n, 5119);
        high_len(0, n);   chk(n == 32, "R13", n, 32);

        cur_req = "R5";
        servo_count = 3'd0;
        repeat (10) @(negedge clk);
        seen = '0;
        repeat (11000) @(negedge clk);
        chk(seen == '0 && running, "R5", int'({running, seen}), 16);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule